// File: doc/BRIEF.md
# Ready-Countdown Bus Bridge

This block sits between a processor-side request port and a synchronous memory-mapped bus master that is paced by a wait-request input. The processor issues a one-cycle read or write strobe along with an address and write data. The bridge drives the bus transfer and holds it steady for as long as the bus stalls. It captures the read word when the bus accepts the read, and it keeps that word until a later read replaces it.

The bridge does not answer with a single done bit. It returns a small countdown of the cycles that remain until the result is ready. The bus gives no advance notice of completion, so the bridge reports the maximum count while a transfer is stalled or queued, then drops straight to zero. A requester that uses only "count is zero" sees an ordinary ready signal. A requester that reads the count can restart its pipeline early.

A strobe that arrives while a transfer is still in flight is queued as a single pending request and issued when the bridge returns to idle. Only one request may be pending at a time. A further strobe while one is pending, or while a pending request is being issued from idle, is dropped. Bursts, overlapping transfers and arbitration are not handled here.

Top module: `cdwn_bridge`

## Requirements
- R1: After reset, bus_rd, bus_wr and rdy_cnt are 0 and rd_data is 0.
- R2: A read strobe taken in idle drives bus_rd and bus_addr equal to req_addr in the same cycle. The word on bus_rdata in the cycle the bus accepts it (bus_rd high, bus_waitreq low) appears on rd_data in the following cycle.
- R3: While a transfer is stalled (command out with bus_waitreq high), rdy_cnt reads 3 from the cycle after the strobe onward. In the cycle after acceptance it jumps straight to 0.
- R4: While bus_waitreq is high and a command is out, bus_addr, bus_wdata, bus_rd and bus_wr stay unchanged into the next cycle.
- R5: In the cycle right after the bus accepts a transfer, bus_rd and bus_wr are both 0.
- R6: rd_data changes only in the cycle after a read is accepted. Writes leave it unchanged.
- R7: Address and write data are latched on the strobe. Changes to req_addr or req_wdata after the strobe cycle do not alter the transfer in progress.
- R8: A strobe that arrives while the bridge is not idle is queued. rdy_cnt stays 3 until the queued request is issued from idle with its own address and data.
- R9: A write drives bus_wr with req_wdata. rdy_cnt is 0 in the cycle after the write is accepted.
- R10: bus_rd and bus_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | One-cycle read strobe |
| req_wr | input | 1 | One-cycle write strobe |
| req_addr | input | ADDR_W | Request address, sampled on the strobe |
| req_wdata | input | DATA_W | Write data, sampled on the strobe |
| rdy_cnt | output | CNT_W | Cycles remaining until the result (max while busy, 0 when done) |
| rd_data | output | DATA_W | Last read word, held until the next read |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Bus read command |
| bus_wr | output | 1 | Bus write command |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid in the accepting cycle |
| bus_waitreq | input | 1 | Bus stall; the command must be held while high |

## Verification
The bus command appears combinationally in the strobe cycle, so the bench checks it 1 ns after the driving edge, in that same cycle. With a slave that stalls for W cycles, rdy_cnt is checked to read 3 on each of the W cycles that follow the strobe. On cycle W+1 the bench expects rdy_cnt 0, both bus strobes low and the new read word. A queued request must show up on the bus exactly one cycle after its predecessor's completion cycle. All samples are taken on the falling clock edge, and each task counts through these exact cycle offsets instead of polling.

// File: rtl/cdwn_pkg.sv
package cdwn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RDW   = 3'd1,
    ST_RDONE = 3'd2,
    ST_WRW   = 3'd3,
    ST_WDONE = 3'd4
  } cdwn_state_e;
endpackage

// File: rtl/cdwn_fsm.sv
module cdwn_fsm
  import cdwn_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_wr,
  input  logic        waitreq,
  output cdwn_state_e state
);
  cdwn_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (go) begin
        if (go_wr) nxt = waitreq ? ST_WRW : ST_WDONE;
        else       nxt = waitreq ? ST_RDW : ST_RDONE;
      end
      ST_RDW:  if (!waitreq) nxt = ST_RDONE;
      ST_WRW:  if (!waitreq) nxt = ST_WDONE;
      ST_RDONE, ST_WDONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/cdwn_req_hold.sv
module cdwn_req_hold #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_idle,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cmd_valid,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              pend,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);
  logic              pend_wr;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;
  logic              strobe;

  assign strobe    = req_rd | req_wr;
  assign cmd_valid = pend | strobe;
  assign cmd_wr    = pend ? pend_wr    : req_wr;
  assign cmd_addr  = pend ? pend_addr  : req_addr;
  assign cmd_wdata = pend ? pend_wdata : req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_wr    <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      cur_addr   <= '0;
      cur_wdata  <= '0;
    end else if (in_idle) begin
      pend <= 1'b0;
      if (cmd_valid) begin
        cur_addr  <= cmd_addr;
        cur_wdata <= cmd_wdata;
      end
    end else if (strobe && !pend) begin
      pend       <= 1'b1;
      pend_wr    <= req_wr;
      pend_addr  <= req_addr;
      pend_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/cdwn_bridge.sv
module cdwn_bridge
  import cdwn_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [CNT_W-1:0]  rdy_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_waitreq
);
  localparam logic [CNT_W-1:0] CNT_BUSY = {CNT_W{1'b1}};

  cdwn_state_e       state;
  logic              in_idle;
  logic              cmd_valid, cmd_wr, pend;
  logic [ADDR_W-1:0] cmd_addr, cur_addr;
  logic [DATA_W-1:0] cmd_wdata, cur_wdata;
  logic              rd_accept;

  assign in_idle = (state == ST_IDLE);

  cdwn_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_idle(in_idle),
    .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .pend(pend), .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  cdwn_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(cmd_valid), .go_wr(cmd_wr),
    .waitreq(bus_waitreq), .state(state)
  );

  always_comb begin
    if (in_idle) begin
      bus_rd    = cmd_valid & ~cmd_wr;
      bus_wr    = cmd_valid &  cmd_wr;
      bus_addr  = cmd_addr;
      bus_wdata = cmd_wdata;
    end else begin
      bus_rd    = (state == ST_RDW);
      bus_wr    = (state == ST_WRW);
      bus_addr  = cur_addr;
      bus_wdata = cur_wdata;
    end
  end

  assign rdy_cnt = (pend || state == ST_RDW || state == ST_WRW) ? CNT_BUSY : '0;

  assign rd_accept = bus_rd & ~bus_waitreq;

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_accept) rd_data <= bus_rdata;
  end
endmodule

// File: rtl/cdwn_bridge_chk.sv
module cdwn_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  rdy_cnt,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_waitreq
);
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_waitreq && (bus_rd || bus_wr)) |=>
      ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr) && $stable(bus_wdata)));

  a_r5_idle_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_waitreq) |=> (!bus_rd && !bus_wr));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_waitreq) |=> (rd_data == $past(bus_rdata)));

  a_r6_rd_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_waitreq) |=> $stable(rd_data));

  a_r3_busy_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_waitreq) |=> (rdy_cnt == {CNT_W{1'b1}}));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
endmodule

bind cdwn_bridge cdwn_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_cnt(rdy_cnt), .rd_data(rd_data),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq)
);

// File: tb/cdwn_bridge_test.sv
module cdwn_bridge_test;
  localparam int AW = 8, DW = 32, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_rd = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] rdy_cnt;
  logic [DW-1:0] rd_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic bus_rd, bus_wr, bus_waitreq;

  int checks = 0, fails = 0, wtgt = 0, wcnt = 0;
  logic [DW-1:0] smem [16];
  logic [DW-1:0] emem [16];

  always #2 clk = ~clk;

  cdwn_bridge #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy_cnt(rdy_cnt), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq)
  );

  function automatic logic [DW-1:0] seed_word(input int i);
    return (32'h01010101 * i) ^ 32'hA5A5_0000;
  endfunction

  // slave model: stalls each command for wtgt cycles
  assign bus_waitreq = (bus_rd || bus_wr) && (wcnt < wtgt);
  assign bus_rdata   = smem[bus_addr[3:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= 0;
      for (int i = 0; i < 16; i++) smem[i] <= seed_word(i);
    end else if (bus_rd || bus_wr) begin
      if (bus_waitreq) wcnt <= wcnt + 1;
      else begin
        wcnt <= 0;
        if (bus_wr) smem[bus_addr[3:0]] <= bus_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_addr = a; req_wdata = d;
    if (wr) req_wr = 1'b1; else req_rd = 1'b1;
  endtask

  task automatic unstrobe();
    req_rd = 1'b0; req_wr = 1'b0;
    req_addr = AW'($urandom); req_wdata = $urandom; // R7: disturb inputs after strobe
  endtask

  task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int w);
    logic [DW-1:0] prev;
    prev = rd_data;
    @(negedge clk);
    wtgt = w;
    strobe(wr, a, d);
    #1;
    check(bus_rd == !wr && bus_wr == wr, "R2 cmd", {bus_rd, bus_wr}, {!wr, wr});
    check(bus_addr == a, "R2 addr", bus_addr, a);
    @(negedge clk);
    unstrobe();
    for (int k = 1; k <= w; k++) begin
      check(rdy_cnt == 2'd3, "R3 busy count", rdy_cnt, 3);
      check(bus_addr == a, "R7 addr held", bus_addr, a);
      if (wr) check(bus_wdata == d, "R9 wdata held", bus_wdata, d);
      check(!(bus_rd && bus_wr), "R10 exclusive", {bus_rd, bus_wr}, 0);
      @(negedge clk);
    end
    check(rdy_cnt == 2'd0, wr ? "R9 write done count" : "R3 jump to zero", rdy_cnt, 0);
    check(!bus_rd && !bus_wr, "R5 completion", {bus_rd, bus_wr}, 0);
    if (wr) begin
      check(rd_data == prev, "R6 write keeps rd_data", rd_data, prev);
      emem[a[3:0]] = d;
    end else
      check(rd_data == emem[a[3:0]], "R2 read data", rd_data, emem[a[3:0]]);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) emem[i] = seed_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!bus_rd && !bus_wr, "R1 reset bus", {bus_rd, bus_wr}, 0);
    check(rdy_cnt == 0, "R1 reset count", rdy_cnt, 0);
    check(rd_data == 0, "R1 reset rd_data", rd_data, 0);

    // directed: zero-wait read, stalled read, stalled write, read back
    txn(1'b0, 8'd3, '0, 0);
    txn(1'b0, 8'd7, '0, 4);
    txn(1'b1, 8'd7, 32'hDEAD_BEEF, 3);
    txn(1'b1, 8'd2, 32'h1234_5678, 0);
    txn(1'b0, 8'd7, '0, 1);

    // R8: write strobed while a read is stalled
    begin
      logic [DW-1:0] rexp;
      rexp = emem[5];
      @(negedge clk);
      wtgt = 2;
      strobe(1'b0, 8'd5, '0);
      @(negedge clk);
      unstrobe();
      strobe(1'b1, 8'd9, 32'hCAFE_0009);       // arrives in read-wait
      @(negedge clk);
      unstrobe();
      check(rdy_cnt == 2'd3, "R8 queued count", rdy_cnt, 3);
      @(negedge clk);                           // read completion
      check(rd_data == rexp, "R8 first read data", rd_data, rexp);
      check(rdy_cnt == 2'd3, "R8 count while queued", rdy_cnt, 3);
      @(negedge clk);                           // idle, queued write issued
      check(bus_wr && !bus_rd, "R8 queued write issued", {bus_rd, bus_wr}, 2'b01);
      check(bus_addr == 8'd9, "R8 queued addr", bus_addr, 9);
      check(bus_wdata == 32'hCAFE_0009, "R8 queued data", bus_wdata, 32'hCAFE_0009);
      @(negedge clk);
      @(negedge clk);                           // accepted here
      @(negedge clk);
      check(rdy_cnt == 2'd0, "R8 queued done", rdy_cnt, 0);
      check(rd_data == rexp, "R6 rd_data kept over write", rd_data, rexp);
      emem[9] = 32'hCAFE_0009;
      txn(1'b0, 8'd9, '0, 0);
    end

    // random mix
    for (int n = 0; n < 60; n++)
      txn(1'($urandom_range(0, 1)), AW'($urandom_range(0, 15)), $urandom, $urandom_range(0, 4));

    summary();
    $finish;
  end
endmodule